// File: doc/BRIEF.md
# Stack Call Return Sequencer

This block carries out the control-transfer and stack commands of a word-addressed 32-bit machine. There are five of them: return, jump, call, push and pop. The block owns the stack pointer, which grows downward from a reset value set by a parameter. It reports new program-counter values through a one-cycle write pulse. Each command is one request from the surrounding core. That request gives a command kind, three option bits and one register-index field. The core also presents the program counter as it stands after the command word, so the counter points at the word that may follow.

Memory is reached through a single-word load/store port with a ready handshake. A request holds its address, direction and data until ready is seen. A second, combinational port reads one register by index. Immediate words are the word at the current program counter, and they are fetched through the memory port. While a sequence runs, `busy` stays high. New commands are taken only while `busy` is low.

Top module: `stack_xfer_seq`

## Requirements
- R1: After reset the stack pointer equals the SP_RESET parameter, and busy, mem_req, pc_we and rf_we are all low.
- R2: A command is accepted on a clock edge where cmd_valid is high and busy is low. cmd_valid is ignored while busy is high. Command kind 3 is accepted and has no effect on the stack pointer, the program counter, the register file or memory.
- R3: A memory request keeps mem_addr, mem_we and mem_wdata unchanged until the edge where mem_ready is high.
- R4: Kind 0 (transfer) with option bit 0 clear is a return. The stack pointer becomes SP + field + 1, and the program counter is then loaded from memory at that new stack pointer.
- R5: Kind 0 with option bits 1:0 = 01 is a jump. Option bit 2 set takes the target from the register named by field; clear takes it from memory at the current program counter. The stack pointer is unchanged.
- R6: Kind 0 with option bits 2:0 = 111 is a call through a register. The current program counter is stored at SP, the stack pointer then drops by one, and the program counter becomes the register value.
- R7: Kind 0 with option bits 2:0 = 011 is a call with an immediate target. The target is read from memory at the program counter, program counter + 1 is stored at SP, the stack pointer drops by one, and the program counter becomes the target.
- R8: Kind 1 (push) with option bit 0 clear stores the register named by field at SP, then decrements SP. No program-counter write occurs.
- R9: Kind 1 with option bit 0 set reads the value from memory at the program counter, stores it at SP, decrements SP, and writes program counter + 1.
- R10: Kind 2 (pop) increments SP, then loads memory at the new SP and writes it to the register named by field through rf_we.
- R11: Stack-pointer arithmetic wraps modulo 2^32. A push at 0 leaves 0xFFFFFFFF, and a pop from 0xFFFFFFFF reads address 0.
- R12: Stack-pointer adjustments write no other state. rf_we pulses only at the end of a pop, and never together with pc_we.
- R13: busy is high from the edge that accepts a memory-using command until the edge that issues its final write pulse. mem_req is never high while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Command kind: 0 transfer, 1 push, 2 pop, 3 no effect |
| cmd_ext | input | 3 | Option bits |
| cmd_field | input | RIDX_W | Register index or return discard count |
| pc_i | input | DW | Program counter after the command word |
| busy | output | 1 | Sequence in progress |
| pc_we | output | 1 | Program-counter write pulse |
| pc_wdata | output | DW | New program counter |
| rf_ridx | output | RIDX_W | Register read index |
| rf_rdata | input | DW | Register read value |
| rf_we | output | 1 | Register write pulse |
| rf_widx | output | RIDX_W | Register write index |
| rf_wdata | output | DW | Register write value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a store |
| mem_addr | output | DW | Word address |
| mem_wdata | output | DW | Store data |
| mem_rdata | input | DW | Load data |
| mem_ready | input | 1 | Memory completes the request this edge |
| sp_o | output | DW | Current stack pointer |

## Verification
The hardest conditions to reach are two. One is a command offered while a slow memory stalls a store. The other is the stack pointer crossing zero. The bench raises the memory latency and presents a pop in the middle of a pending push. It then checks that only the push moved the stack pointer and that no register write appeared. To cross zero, the bench starts from a small reset value and pushes repeatedly, so the pointer walks down to 0 and wraps. A following pop must then read address 0 back.

// File: rtl/stack_xfer_pkg.sv
package stack_xfer_pkg;
  typedef enum logic [1:0] {
    OP_XFER = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_NONE = 2'd3
  } sx_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IMM,
    ST_STORE,
    ST_POP,
    ST_RET
  } sx_state_e;

  typedef enum logic [1:0] {
    SPA_HOLD,
    SPA_UP,
    SPA_DOWN
  } sx_spadj_e;
endpackage

// File: rtl/stack_xfer_sp.sv
module stack_xfer_sp
  import stack_xfer_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [DW-1:0] SP_RESET = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  sx_spadj_e       adj,
  input  logic [DW-1:0]   amt,
  output logic [DW-1:0]   sp_q,
  output logic [DW-1:0]   sp_up
);
  // upward move by a variable amount, downward always by one word
  assign sp_up = sp_q + amt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= SP_RESET;
    end else begin
      case (adj)
        SPA_UP:   sp_q <= sp_up;
        SPA_DOWN: sp_q <= sp_q - DW'(1);
        default:  sp_q <= sp_q;
      endcase
    end
  end
endmodule

// File: rtl/stack_xfer_memport.sv
module stack_xfer_memport #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          go_we,
  input  logic [DW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  output logic          xfer_done
);
  assign xfer_done = mem_req && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (go) begin
      mem_req   <= 1'b1;
      mem_we    <= go_we;
      mem_addr  <= go_addr;
      mem_wdata <= go_wdata;
    end else if (xfer_done) begin
      mem_req   <= 1'b0;
    end
  end

  // R3: a stalled request keeps its contents
  a_r3_hold_request: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: rtl/stack_xfer_seq.sv
module stack_xfer_seq
  import stack_xfer_pkg::*;
#(
  parameter int            DW       = 32,
  parameter int            RIDX_W   = 5,
  parameter logic [DW-1:0] SP_RESET = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [2:0]        cmd_ext,
  input  logic [RIDX_W-1:0] cmd_field,
  input  logic [DW-1:0]     pc_i,
  output logic              busy,
  output logic              pc_we,
  output logic [DW-1:0]     pc_wdata,
  output logic [RIDX_W-1:0] rf_ridx,
  input  logic [DW-1:0]     rf_rdata,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_widx,
  output logic [DW-1:0]     rf_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ready,
  output logic [DW-1:0]     sp_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  sx_state_e           state;
  sx_op_e              op_q;
  logic [1:0]          ext_q;
  logic [RIDX_W-1:0]   field_q;
  logic [DW-1:0]       pc_q;
  logic [DW-1:0]       val_q;

  sx_op_e              cmd_kind;
  sx_spadj_e           sp_adj;
  logic [DW-1:0]       sp_amt;
  logic [DW-1:0]       sp_up;
  logic                go, go_we, xfer_done;
  logic [DW-1:0]       go_addr, go_wdata;
  logic                accept;

  assign cmd_kind = sx_op_e'(cmd_op);
  assign accept   = cmd_valid && (state == ST_IDLE);
  assign rf_ridx  = cmd_field;

  stack_xfer_sp #(.DW(DW), .SP_RESET(SP_RESET)) sp_i (
    .clk(clk), .rst(rst), .adj(sp_adj), .amt(sp_amt),
    .sp_q(sp_o), .sp_up(sp_up)
  );

  stack_xfer_memport #(.DW(DW)) mp_i (
    .clk(clk), .rst(rst), .go(go), .go_we(go_we), .go_addr(go_addr),
    .go_wdata(go_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .xfer_done(xfer_done)
  );

  // request issue and stack-pointer moves
  always_comb begin
    go       = 1'b0;
    go_we    = 1'b0;
    go_addr  = '0;
    go_wdata = '0;
    sp_adj   = SPA_HOLD;
    sp_amt   = '0;
    case (state)
      ST_IDLE: begin
        if (cmd_valid) begin
          case (cmd_kind)
            OP_XFER: begin
              if (!cmd_ext[0]) begin
                // return: raise by discard count plus one, then load
                sp_adj  = SPA_UP;
                sp_amt  = DW'(cmd_field) + ONE;
                go      = 1'b1;
                go_addr = sp_up;
              end else if (!cmd_ext[2]) begin
                go      = 1'b1;
                go_addr = pc_i;
              end else if (cmd_ext[1]) begin
                go       = 1'b1;
                go_we    = 1'b1;
                go_addr  = sp_o;
                go_wdata = pc_i;
              end
            end
            OP_PUSH: begin
              go = 1'b1;
              if (cmd_ext[0]) begin
                go_addr = pc_i;
              end else begin
                go_we    = 1'b1;
                go_addr  = sp_o;
                go_wdata = rf_rdata;
              end
            end
            OP_POP: begin
              sp_adj  = SPA_UP;
              sp_amt  = ONE;
              go      = 1'b1;
              go_addr = sp_up;
            end
            default: ;
          endcase
        end
      end
      ST_IMM: begin
        if (xfer_done) begin
          if (op_q == OP_PUSH) begin
            go       = 1'b1;
            go_we    = 1'b1;
            go_addr  = sp_o;
            go_wdata = mem_rdata;
          end else if (ext_q[1]) begin
            go       = 1'b1;
            go_we    = 1'b1;
            go_addr  = sp_o;
            go_wdata = pc_q + ONE;
          end
        end
      end
      ST_STORE: begin
        if (xfer_done) sp_adj = SPA_DOWN;
      end
      default: ;
    endcase
  end

  // sequence state and registered write pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      pc_we    <= 1'b0;
      pc_wdata <= '0;
      rf_we    <= 1'b0;
      rf_widx  <= '0;
      rf_wdata <= '0;
      op_q     <= OP_NONE;
      ext_q    <= '0;
      field_q  <= '0;
      pc_q     <= '0;
      val_q    <= '0;
    end else begin
      pc_we <= 1'b0;
      rf_we <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            op_q    <= cmd_kind;
            ext_q   <= cmd_ext[1:0];
            field_q <= cmd_field;
            pc_q    <= pc_i;
            val_q   <= rf_rdata;
            case (cmd_kind)
              OP_XFER: begin
                if (!cmd_ext[0]) begin
                  state <= ST_RET;
                  busy  <= 1'b1;
                end else if (!cmd_ext[2]) begin
                  state <= ST_IMM;
                  busy  <= 1'b1;
                end else if (cmd_ext[1]) begin
                  state <= ST_STORE;
                  busy  <= 1'b1;
                end else begin
                  pc_we    <= 1'b1;
                  pc_wdata <= rf_rdata;
                end
              end
              OP_PUSH: begin
                state <= cmd_ext[0] ? ST_IMM : ST_STORE;
                busy  <= 1'b1;
              end
              OP_POP: begin
                state <= ST_POP;
                busy  <= 1'b1;
              end
              default: ;
            endcase
          end
        end
        ST_IMM: begin
          if (xfer_done) begin
            val_q <= mem_rdata;
            if (op_q == OP_PUSH || ext_q[1]) begin
              state <= ST_STORE;
            end else begin
              pc_we    <= 1'b1;
              pc_wdata <= mem_rdata;
              state    <= ST_IDLE;
              busy     <= 1'b0;
            end
          end
        end
        ST_STORE: begin
          if (xfer_done) begin
            if (op_q == OP_XFER) begin
              pc_we    <= 1'b1;
              pc_wdata <= val_q;
            end else if (ext_q[0]) begin
              pc_we    <= 1'b1;
              pc_wdata <= pc_q + ONE;
            end
            state <= ST_IDLE;
            busy  <= 1'b0;
          end
        end
        ST_RET: begin
          if (xfer_done) begin
            pc_we    <= 1'b1;
            pc_wdata <= mem_rdata;
            state    <= ST_IDLE;
            busy     <= 1'b0;
          end
        end
        ST_POP: begin
          if (xfer_done) begin
            rf_we    <= 1'b1;
            rf_widx  <= field_q;
            rf_wdata <= mem_rdata;
            state    <= ST_IDLE;
            busy     <= 1'b0;
          end
        end
        default: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
        end
      endcase
    end
  end

  // R13: memory traffic only inside a busy sequence
  a_r13_req_inside_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R12: register writes only finish a pop, never with a PC write
  a_r12_rf_only_from_pop: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> ($past(state) == ST_POP));
  a_r12_no_dual_write: assert property (@(posedge clk) disable iff (rst)
    !(pc_we && rf_we));

  // R8: a completed store is followed by a one-word descent
  a_r8_store_then_down: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STORE && xfer_done) |=> (sp_o == $past(sp_o) - ONE));

  // R10 / R4: loads from the stack use the already adjusted pointer
  a_r10_load_at_new_sp: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_POP || state == ST_RET) && mem_req) |-> (mem_addr == sp_o));
endmodule

// File: tb/stack_xfer_seq_tb_top.sv
module stack_xfer_seq_tb_top;
  localparam int DW = 32;
  localparam int RW = 5;
  localparam logic [DW-1:0] SPR = 32'h0000_0008;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd3;
  logic [2:0] cmd_ext = 3'd0;
  logic [RW-1:0] cmd_field = '0;
  logic [DW-1:0] pc_i = '0;
  logic busy, pc_we, rf_we, mem_req, mem_we;
  logic mem_ready = 1'b0;
  logic [DW-1:0] pc_wdata, rf_wdata, mem_addr, mem_wdata, sp_o, rf_rdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [RW-1:0] rf_ridx, rf_widx;

  logic [DW-1:0] rf [32];
  bit [31:0] mem [bit [31:0]];
  int unsigned age = 0;
  int unsigned lat = 0;

  int checks = 0;
  int errors = 0;
  int pc_cnt = 0;
  int rf_cnt = 0;
  logic [DW-1:0] pc_last = '0;
  logic [DW-1:0] rf_last = '0;
  logic [RW-1:0] rf_idx_last = '0;
  logic [DW-1:0] sp_exp;

  always #10 clk = ~clk;

  assign rf_rdata = rf[rf_ridx];

  stack_xfer_seq #(.DW(DW), .RIDX_W(RW), .SP_RESET(SPR)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ext(cmd_ext), .cmd_field(cmd_field), .pc_i(pc_i), .busy(busy),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .rf_ridx(rf_ridx),
    .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_widx(rf_widx),
    .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .sp_o(sp_o)
  );

  // memory model with programmable latency
  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (mem_we) mem[mem_addr] = mem_wdata;
      age <= 0;
    end else if (mem_req) begin
      age <= age + 1;
    end else begin
      age <= 0;
    end
  end

  always @(negedge clk) begin
    mem_ready <= mem_req && (age >= lat);
    mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
  end

  // write-pulse monitor
  always @(negedge clk) begin
    if (pc_we) begin pc_cnt++; pc_last = pc_wdata; end
    if (rf_we) begin rf_cnt++; rf_last = rf_wdata; rf_idx_last = rf_widx; end
  end

  function automatic logic [31:0] rdmem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [2:0] ext, input logic [RW-1:0] fld);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_ext = ext; cmd_field = fld;
    pc_cnt = 0; rf_cnt = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 sp", sp_o, SPR);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 pc_we", 32'(pc_we), 0);
    chk("R1 rf_we", 32'(rf_we), 0);
  endtask

  task automatic t_push_reg();
    logic [31:0] s = sp_exp;
    rf[3] = 32'hAAAA_0003;
    run_cmd(2'd1, 3'b000, 5'd3);
    sp_exp = s - 1;
    chk("R8 stored", rdmem(s), 32'hAAAA_0003);
    chk("R8 sp", sp_o, sp_exp);
    chk("R8 no pc write", 32'(pc_cnt), 0);
    chk("R12 no rf write on push", 32'(rf_cnt), 0);
  endtask

  task automatic t_push_imm();
    logic [31:0] s = sp_exp;
    pc_i = 32'h200; mem[32'h200] = 32'h1234_5678;
    lat = 1;
    run_cmd(2'd1, 3'b001, 5'd0);
    sp_exp = s - 1;
    chk("R9 stored", rdmem(s), 32'h1234_5678);
    chk("R9 sp", sp_o, sp_exp);
    chk("R9 pc advance", pc_last, 32'h201);
    chk("R9 pc writes", 32'(pc_cnt), 1);
  endtask

  task automatic t_pop();
    run_cmd(2'd2, 3'b000, 5'd7);
    sp_exp = sp_exp + 1;
    chk("R10 sp", sp_o, sp_exp);
    chk("R10 data", rf_last, 32'h1234_5678);
    chk("R10 index", 32'(rf_idx_last), 7);
    chk("R10 one write", 32'(rf_cnt), 1);
  endtask

  task automatic t_call_imm();
    logic [31:0] s = sp_exp;
    pc_i = 32'h300; mem[32'h300] = 32'h500;
    lat = 2;
    run_cmd(2'd0, 3'b011, 5'd0);
    sp_exp = s - 1;
    chk("R7 return addr", rdmem(s), 32'h301);
    chk("R7 sp", sp_o, sp_exp);
    chk("R7 pc", pc_last, 32'h500);
  endtask

  task automatic t_call_reg();
    logic [31:0] s = sp_exp;
    pc_i = 32'h600; rf[5] = 32'h700;
    lat = 0;
    run_cmd(2'd0, 3'b111, 5'd5);
    sp_exp = s - 1;
    chk("R6 return addr", rdmem(s), 32'h600);
    chk("R6 sp", sp_o, sp_exp);
    chk("R6 pc", pc_last, 32'h700);
  endtask

  task automatic t_ret();
    run_cmd(2'd0, 3'b000, 5'd1);
    sp_exp = sp_exp + 2;
    chk("R4 sp", sp_o, sp_exp);
    chk("R4 pc skips discarded word", pc_last, 32'h301);
    chk("R12 no rf write on ret", 32'(rf_cnt), 0);
  endtask

  task automatic t_jumps();
    pc_i = 32'h800; mem[32'h800] = 32'h900;
    run_cmd(2'd0, 3'b001, 5'd0);
    chk("R5 imm target", pc_last, 32'h900);
    chk("R5 imm sp", sp_o, sp_exp);
    run_cmd(2'd0, 3'b101, 5'd5);
    chk("R5 reg target", pc_last, 32'h700);
    chk("R5 reg sp", sp_o, sp_exp);
    chk("R5 single write", 32'(pc_cnt), 1);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] s = sp_exp;
    rf[9] = 32'hBEEF_0009;
    lat = 4;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_ext = 3'b000; cmd_field = 5'd9;
    pc_cnt = 0; rf_cnt = 0;
    @(negedge clk);
    cmd_op = 2'd2; cmd_field = 5'd4;
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    #1;
    sp_exp = s - 1;
    chk("R2 busy stored", rdmem(s), 32'hBEEF_0009);
    chk("R2 sp only push", sp_o, sp_exp);
    chk("R2 pop ignored", 32'(rf_cnt), 0);
    lat = 0;
    run_cmd(2'd3, 3'b111, 5'd2);
    chk("R2 kind3 sp", sp_o, sp_exp);
    chk("R2 kind3 no pc", 32'(pc_cnt), 0);
    chk("R2 kind3 no rf", 32'(rf_cnt), 0);
    chk("R13 kind3 idle", 32'(busy), 0);
  endtask

  task automatic t_wrap();
    rf[1] = 32'hC0DE_0001;
    while (sp_exp != 0) begin
      run_cmd(2'd1, 3'b000, 5'd1);
      sp_exp = sp_exp - 1;
    end
    chk("R11 at zero", sp_o, 32'h0);
    rf[1] = 32'h5A5A_0000;
    run_cmd(2'd1, 3'b000, 5'd1);
    chk("R11 wrap down", sp_o, 32'hFFFF_FFFF);
    chk("R11 stored at 0", rdmem(32'h0), 32'h5A5A_0000);
    run_cmd(2'd2, 3'b000, 5'd2);
    chk("R11 wrap up", sp_o, 32'h0);
    chk("R11 pop from 0", rf_last, 32'h5A5A_0000);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 32'(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    sp_exp = SPR;
    t_push_reg();
    t_push_imm();
    t_pop();
    t_call_imm();
    t_call_reg();
    t_ret();
    t_jumps();
    t_busy_ignore();
    t_wrap();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule